// File: doc/BRIEF.md
# Decimal/Binary Accumulator Adder-Subtractor

This unit is the add-with-carry and subtract-with-borrow datapath of an accumulator machine. It takes the current accumulator, a memory operand and the incoming carry, and produces the new accumulator together with carry, overflow, zero and negative flags. One input selects packed-BCD or plain binary arithmetic. Another selects a narrow (8-bit) or wide (16-bit) operation.

In decimal mode each 4-bit digit is summed or differenced and then corrected. The correction ripples from the lowest digit upward, and the top active digit produces the carry. A narrow operation works on the low byte only. The accumulator's upper byte is passed through unchanged. A one-cycle `start_i` pulse loads the result and flags into output registers on the next clock edge and raises `done_o` for that cycle. Operand fetch and instruction decode happen elsewhere.

Top module: `decadd_unit`

## Requirements
- R1: Binary add (`sub_i`=0, `dec_i`=0) gives acc+opnd+carry_i at the active width. Carry is set when the sum exceeds 0xFF (narrow) or 0xFFFF (wide).
- R2: Binary subtract (`sub_i`=1, `dec_i`=0) gives acc−opnd+carry_i−1 at the active width. Carry is set exactly when that true result is zero or greater.
- R3: Decimal add processes 4-bit digits from bit 0 upward. For each digit, s = acc digit + opnd digit + incoming link, where the link into digit 0 is carry_i. If s > 9 the digit becomes (s−10) mod 16 and the link out is 1; otherwise the digit is s and the link out is 0. Carry equals the link out of the top active digit (digit 1 narrow, digit 3 wide).
- R4: Decimal subtract uses d = acc digit − opnd digit − incoming borrow, where the borrow into digit 0 is the inverse of carry_i. If d < 0 or d > 9 the digit becomes (d+10) mod 16 and the borrow out is 1; otherwise the digit is d. Carry is the inverse of the top active digit's borrow out.
- R5: For add, in both modes, overflow is set when acc and opnd have equal sign bits and the result's sign bit differs from opnd. The sign bit is bit 7 narrow and bit 15 wide.
- R6: For subtract, in both modes, overflow is set when acc and opnd differ in sign bit and the result's sign bit differs from acc.
- R7: Zero is set exactly when the result at the active width is all zeros.
- R8: Negative equals the result's bit 7 (narrow) or bit 15 (wide).
- R9: In narrow mode (`wide_i`=0), `acc_o[15:8]` takes `acc_i[15:8]` unchanged.
- R10: Outputs update on the clock edge that samples `start_i`=1, and `done_o` is high for exactly the cycle after it. Without `start_i`, all outputs hold and `done_o` is low.
- R11: Reset clears the accumulator, all four flags and `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Perform the operation at this edge |
| sub_i | input | 1 | 1 = subtract with borrow, 0 = add with carry |
| wide_i | input | 1 | 1 = 16-bit, 0 = 8-bit on low byte |
| dec_i | input | 1 | 1 = packed BCD, 0 = binary |
| carry_i | input | 1 | Incoming carry flag |
| acc_i | input | 16 | Current accumulator |
| opnd_i | input | 16 | Memory operand |
| acc_o | output | 16 | Registered new accumulator |
| carry_o | output | 1 | Registered carry flag |
| ovf_o | output | 1 | Registered overflow flag |
| zero_o | output | 1 | Registered zero flag |
| neg_o | output | 1 | Registered negative flag |
| done_o | output | 1 | High for the cycle after an accepted start |

## Verification
The bench uses the default widths: a 16-bit accumulator and an 8-bit narrow slice, which together give four decimal digits wide and two narrow. At these sizes every pair of valid two-digit BCD values can be run through narrow decimal add and subtract, with random carry. Random operands cover the wide mode and binary arithmetic. Random nibbles above 9 exercise the correction rule for invalid digits.

// File: rtl/decadd_pkg.sv
package decadd_pkg;
    parameter int DECADD_W = 16;

    typedef struct packed {
        logic carry;
        logic ovf;
        logic zero;
        logic neg;
    } decadd_flags_t;

    typedef struct packed {
        logic [DECADD_W-1:0] acc;
        decadd_flags_t       flags;
        logic                done;
    } decadd_state_t;
endpackage

// File: rtl/decadd_bcd_chain.sv
module decadd_bcd_chain #(
    parameter int NDIG  = 4,
    parameter int DIG_W = 4
) (
    input  logic [NDIG*DIG_W-1:0] a_i,
    input  logic [NDIG*DIG_W-1:0] w_i,
    input  logic                  sub_i,
    input  logic                  cin_i,
    output logic [NDIG*DIG_W-1:0] res_o,
    output logic [NDIG-1:0]       link_o
);
    localparam int RADIX = 10;

    // link = carry for add, borrow for subtract
    logic [NDIG:0] link;
    assign link[0] = sub_i ? ~cin_i : cin_i;

    for (genvar g = 0; g < NDIG; g++) begin : g_dig
        logic [DIG_W-1:0] ad, wd;
        logic [DIG_W:0]   sum;
        logic [DIG_W+1:0] dif;
        logic             over, under;

        assign ad    = a_i[g*DIG_W +: DIG_W];
        assign wd    = w_i[g*DIG_W +: DIG_W];
        assign sum   = {1'b0, ad} + {1'b0, wd} + {{DIG_W{1'b0}}, link[g]};
        assign dif   = {2'b00, ad} - {2'b00, wd} - {{(DIG_W+1){1'b0}}, link[g]};
        assign over  = sum > (DIG_W+1)'(RADIX-1);
        // a negative difference reads as a large unsigned value
        assign under = dif > (DIG_W+2)'(RADIX-1);

        always_comb begin
            if (sub_i)
                res_o[g*DIG_W +: DIG_W] = under ? dif[DIG_W-1:0] + DIG_W'(RADIX) : dif[DIG_W-1:0];
            else
                res_o[g*DIG_W +: DIG_W] = over ? sum[DIG_W-1:0] - DIG_W'(RADIX) : sum[DIG_W-1:0];
        end
        assign link[g+1] = sub_i ? under : over;
    end

    assign link_o = link[NDIG:1];
endmodule

// File: rtl/decadd_bin.sv
module decadd_bin #(
    parameter int DATA_W   = 16,
    parameter int NARROW_W = 8
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] w_i,
    input  logic              sub_i,
    input  logic              cin_i,
    output logic [DATA_W-1:0] res_o,
    output logic              c_narrow_o,
    output logic              c_wide_o
);
    localparam int HI_W = DATA_W - NARROW_W;

    logic [DATA_W-1:0]   wx;
    logic [NARROW_W:0]   lo;
    logic [HI_W:0]       hi;

    // subtract as a + ~w + c: carry out is the "no borrow" indication
    assign wx = sub_i ? ~w_i : w_i;
    assign lo = {1'b0, a_i[NARROW_W-1:0]} + {1'b0, wx[NARROW_W-1:0]}
              + {{NARROW_W{1'b0}}, cin_i};
    assign hi = {1'b0, a_i[DATA_W-1:NARROW_W]} + {1'b0, wx[DATA_W-1:NARROW_W]}
              + {{HI_W{1'b0}}, lo[NARROW_W]};

    assign res_o      = {hi[HI_W-1:0], lo[NARROW_W-1:0]};
    assign c_narrow_o = lo[NARROW_W];
    assign c_wide_o   = hi[HI_W];
endmodule

// File: rtl/decadd_unit.sv
module decadd_unit
    import decadd_pkg::*;
#(
    parameter int DATA_W   = DECADD_W,
    parameter int NARROW_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              sub_i,
    input  logic              wide_i,
    input  logic              dec_i,
    input  logic              carry_i,
    input  logic [DATA_W-1:0] acc_i,
    input  logic [DATA_W-1:0] opnd_i,
    output logic [DATA_W-1:0] acc_o,
    output logic              carry_o,
    output logic              ovf_o,
    output logic              zero_o,
    output logic              neg_o,
    output logic              done_o
);
    localparam int DIG_W  = 4;
    localparam int NDIG   = DATA_W / DIG_W;
    localparam int NDIG_N = NARROW_W / DIG_W;

    logic [DATA_W-1:0] bcd_res, bin_res, res;
    logic [NDIG-1:0]   bcd_link;
    logic              bin_c_n, bin_c_w;
    logic              top_link, cy, sa, sw, sr, ovf, zro;

    decadd_state_t st_d, st_q;

    decadd_bcd_chain #(.NDIG(NDIG), .DIG_W(DIG_W)) u_bcd (
        .a_i    (acc_i),
        .w_i    (opnd_i),
        .sub_i  (sub_i),
        .cin_i  (carry_i),
        .res_o  (bcd_res),
        .link_o (bcd_link)
    );

    decadd_bin #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_bin (
        .a_i        (acc_i),
        .w_i        (opnd_i),
        .sub_i      (sub_i),
        .cin_i      (carry_i),
        .res_o      (bin_res),
        .c_narrow_o (bin_c_n),
        .c_wide_o   (bin_c_w)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;

        res      = dec_i ? bcd_res : bin_res;
        top_link = wide_i ? bcd_link[NDIG-1] : bcd_link[NDIG_N-1];
        if (dec_i)
            cy = sub_i ? ~top_link : top_link;
        else
            cy = wide_i ? bin_c_w : bin_c_n;

        sa = wide_i ? acc_i[DATA_W-1]  : acc_i[NARROW_W-1];
        sw = wide_i ? opnd_i[DATA_W-1] : opnd_i[NARROW_W-1];
        sr = wide_i ? res[DATA_W-1]    : res[NARROW_W-1];
        if (sub_i)
            ovf = (sa ^ sw) & (sa ^ sr);
        else
            ovf = ~(sa ^ sw) & (sw ^ sr);
        zro = wide_i ? (res == '0) : (res[NARROW_W-1:0] == '0);

        if (start_i) begin
            st_d.acc         = wide_i ? res : {acc_i[DATA_W-1:NARROW_W], res[NARROW_W-1:0]};
            st_d.flags.carry = cy;
            st_d.flags.ovf   = ovf;
            st_d.flags.zero  = zro;
            st_d.flags.neg   = sr;
            st_d.done        = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign acc_o   = st_q.acc;
    assign carry_o = st_q.flags.carry;
    assign ovf_o   = st_q.flags.ovf;
    assign zero_o  = st_q.flags.zero;
    assign neg_o   = st_q.flags.neg;
    assign done_o  = st_q.done;
endmodule

// File: rtl/decadd_chk.sv
module decadd_chk #(
    parameter int DATA_W   = 16,
    parameter int NARROW_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              wide_i,
    input logic [DATA_W-1:0] acc_i,
    input logic [DATA_W-1:0] acc_o,
    input logic              carry_o,
    input logic              ovf_o,
    input logic              zero_o,
    input logic              neg_o,
    input logic              done_o
);
    logic wide_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       wide_q <= 1'b0;
        else if (start_i) wide_q <= wide_i;
    end

    AST_DONE_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> done_o); // R10
    AST_NO_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> !done_o); // R10
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> ($stable(acc_o) && $stable(carry_o) && $stable(ovf_o)
                      && $stable(zero_o) && $stable(neg_o))); // R10
    AST_NARROW_HIGH_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !wide_i) |=> (acc_o[DATA_W-1:NARROW_W] == $past(acc_i[DATA_W-1:NARROW_W]))); // R9
    AST_ZERO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (zero_o == (wide_q ? (acc_o == '0) : (acc_o[NARROW_W-1:0] == '0)))); // R7
    AST_NEG_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (neg_o == (wide_q ? acc_o[DATA_W-1] : acc_o[NARROW_W-1]))); // R8
    AST_ZERO_NOT_NEG: assert property (@(posedge clk) disable iff (!rst_n)
        zero_o |-> !neg_o); // R7
endmodule

bind decadd_unit decadd_chk #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .wide_i  (wide_i),
    .acc_i   (acc_i),
    .acc_o   (acc_o),
    .carry_o (carry_o),
    .ovf_o   (ovf_o),
    .zero_o  (zero_o),
    .neg_o   (neg_o),
    .done_o  (done_o)
);

// File: tb/tb_decadd_unit.sv
module tb_decadd_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0, sub_i = 1'b0, wide_i = 1'b0, dec_i = 1'b0, carry_i = 1'b0;
    logic [15:0] acc_i = '0, opnd_i = '0;
    logic [15:0] acc_o;
    logic        carry_o, ovf_o, zero_o, neg_o, done_o;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    decadd_unit dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .sub_i(sub_i), .wide_i(wide_i),
        .dec_i(dec_i), .carry_i(carry_i), .acc_i(acc_i), .opnd_i(opnd_i),
        .acc_o(acc_o), .carry_o(carry_o), .ovf_o(ovf_o), .zero_o(zero_o),
        .neg_o(neg_o), .done_o(done_o)
    );

    // expected {acc[15:0], carry, ovf, zero, neg}
    function automatic logic [19:0] ref_op(logic [15:0] a, logic [15:0] w, logic c,
                                           logic sub, logic wide, logic dec);
        int nb = wide ? 16 : 8;
        int mask = (1 << nb) - 1;
        int r = 0;
        int cy, t;
        logic sa, sw, sr, v;
        logic [15:0] full;
        if (dec) begin
            int link = sub ? (c ? 0 : 1) : (c ? 1 : 0);
            for (int k = 0; k < nb / 4; k++) begin
                int ad = (a >> (4 * k)) & 15;
                int wd = (w >> (4 * k)) & 15;
                if (!sub) begin
                    t = ad + wd + link;
                    if (t > 9) begin t = (t - 10) & 15; link = 1; end
                    else link = 0;
                end else begin
                    t = ad - wd - link;
                    if (t < 0 || t > 9) begin t = (t + 10) & 15; link = 1; end
                    else link = 0;
                end
                r = r | (t << (4 * k));
            end
            cy = sub ? 1 - link : link;
        end else begin
            int am = a & mask;
            int wm = w & mask;
            if (!sub) begin
                t = am + wm + (c ? 1 : 0);
                cy = (t >> nb) & 1;
            end else begin
                t = am - wm + (c ? 1 : 0) - 1;
                cy = (t >= 0) ? 1 : 0;
            end
            r = t & mask;
        end
        sa = a[nb-1];
        sw = w[nb-1];
        sr = r[nb-1];
        v  = sub ? ((sa ^ sw) & (sa ^ sr)) : (~(sa ^ sw) & (sw ^ sr));
        full = wide ? r[15:0] : {a[15:8], r[7:0]};
        return {full, cy[0], v, (r == 0), sr};
    endfunction

    task automatic check(string tag, string what, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // called at a falling edge; returns at the next falling edge with results checked
    task automatic do_op(logic [15:0] a, logic [15:0] w, logic c,
                         logic sub, logic wide, logic dec);
        logic [19:0] e = ref_op(a, w, c, sub, wide, dec);
        string mtag = dec ? (sub ? "R4" : "R3") : (sub ? "R2" : "R1");
        acc_i = a; opnd_i = w; carry_i = c; sub_i = sub; wide_i = wide; dec_i = dec;
        start_i = 1'b1;
        @(negedge clk);
        check(mtag, "acc_low", {8'h00, acc_o[7:0]}, {8'h00, e[11:4]});
        if (wide) check(mtag, "acc_high", {8'h00, acc_o[15:8]}, {8'h00, e[19:12]});
        else      check("R9", "acc_high_kept", {8'h00, acc_o[15:8]}, {8'h00, e[19:12]});
        check(mtag, "carry", {15'h0, carry_o}, {15'h0, e[3]});
        check(sub ? "R6" : "R5", "ovf", {15'h0, ovf_o}, {15'h0, e[2]});
        check("R7", "zero", {15'h0, zero_o}, {15'h0, e[1]});
        check("R8", "neg", {15'h0, neg_o}, {15'h0, e[0]});
        check("R10", "done", {15'h0, done_o}, 16'h0001);
    endtask

    function automatic logic [7:0] to_bcd(int n);
        return {4'(n / 10), 4'(n % 10)};
    endfunction

    task automatic finish_run;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [15:0] hold_acc;
        void'($urandom(32'h1234_5eed));
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11", "acc_reset", acc_o, 16'h0000);
        check("R11", "flags_reset", {11'h0, carry_o, ovf_o, zero_o, neg_o, done_o}, 16'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // directed corners
        do_op(16'h0099, 16'h0001, 1'b0, 1'b0, 1'b0, 1'b1); // R3 99+1 -> 00 carry
        do_op(16'h9999, 16'h0000, 1'b1, 1'b0, 1'b1, 1'b1); // R3 wide wrap
        do_op(16'h0000, 16'h0001, 1'b1, 1'b1, 1'b0, 1'b1); // R4 borrow -> 99
        do_op(16'h1000, 16'h0001, 1'b1, 1'b1, 1'b1, 1'b1); // R4 ripple borrow
        do_op(16'hAB7F, 16'h0001, 1'b0, 1'b0, 1'b0, 1'b0); // R5 R9 signed overflow
        do_op(16'h8000, 16'h0001, 1'b1, 1'b1, 1'b1, 1'b0); // R6 wide overflow
        do_op(16'hFFFF, 16'h0001, 1'b0, 1'b0, 1'b1, 1'b0); // R1 R7 carry and zero
        do_op(16'h0050, 16'h0050, 1'b1, 1'b1, 1'b0, 1'b0); // R2 R7 equal
        do_op(16'h00FF, 16'h00FF, 1'b1, 1'b0, 1'b0, 1'b1); // R3 invalid digits

        // R3 R4: every valid narrow BCD pair, random carry
        for (int x = 0; x < 100; x++) begin
            for (int y = 0; y < 100; y++) begin
                logic [15:0] hb = 16'($urandom);
                do_op({hb[15:8], to_bcd(x)}, {hb[7:0], to_bcd(y)}, 1'($urandom), 1'b0, 1'b0, 1'b1);
                do_op({hb[7:0], to_bcd(x)}, {hb[15:8], to_bcd(y)}, 1'($urandom), 1'b1, 1'b0, 1'b1);
            end
        end
        // R1 R2: random binary, both widths
        for (int i = 0; i < 12000; i++)
            do_op(16'($urandom), 16'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'b0);
        // R3 R4: random wide valid BCD
        for (int i = 0; i < 8000; i++) begin
            logic [15:0] a = {to_bcd($urandom % 100), to_bcd($urandom % 100)};
            logic [15:0] w = {to_bcd($urandom % 100), to_bcd($urandom % 100)};
            do_op(a, w, 1'($urandom), 1'($urandom), 1'b1, 1'b1);
        end
        // R3 R4: arbitrary nibbles including invalid digits
        for (int i = 0; i < 4000; i++)
            do_op(16'($urandom), 16'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'b1);

        // R10: idle cycles hold outputs even with changing inputs
        start_i = 1'b0;
        hold_acc = acc_o;
        acc_i = 16'h1357; opnd_i = 16'h2468; carry_i = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R10", "done_idle", {15'h0, done_o}, 16'h0);
        check("R10", "acc_hold", acc_o, hold_acc);

        // R11: reset in mid-run clears everything
        do_op(16'h8000, 16'h8000, 1'b1, 1'b0, 1'b1, 1'b0);
        start_i = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        check("R11", "acc_rerst", acc_o, 16'h0000);
        check("R11", "flags_rerst", {11'h0, carry_o, ovf_o, zero_o, neg_o, done_o}, 16'h0);
        finish_run();
    end
endmodule